// File: doc/BRIEF.md
# Pulse-Width Counter with Block Averaging

This block digitises the on-time of a repetitive pulse coming from a capacitance-to-duty-cycle comparator. It divides its own fast clock to produce the sampling signal that drives the analog reset switch, so each conversion period is locked to the counting clock. A sample is the number of clock cycles between the rising edge of the sampling signal and the falling edge of the comparator pulse. The comparator is asynchronous, so it passes through a synchroniser. The start of the count is delayed by the same number of stages, so the count reflects the true pulse width.

Every raw sample is presented with a one-cycle strobe. Samples are also summed over a window of 2^E samples, and the sum is shifted right by E to form an averaged result with its own strobe. A larger E gives more resolution per result and fewer results per second. E is read at run time and takes effect only at the start of a window. A pulse whose falling edge never arrives within its period yields a saturated sample with an overflow flag, and that value still enters the average.

Top module: `pulse_avg_top`

## Requirements
- R1: While reset is asserted, samp_out, raw_valid, avg_valid and raw_ovf are 0, and raw_data and avg_data are 0.
- R2: samp_out repeats every P+1 clock cycles and is high for floor(P/2)+1 of them, where P is div_period. A div_period of 0 behaves as 1.
- R3: Let samp_out rise at clock edge E0, and let comp_async be low from just after edge EL on (L >= 1). Then raw_valid pulses for one cycle after edge E(L+3), with raw_data = L and raw_ovf = 0. raw_valid stays 0 after edge E(L+2).
- R4: Only the first comparator falling edge after a sampling rise ends a sample. Rising edges, and further falling edges within the same period, produce no strobe.
- R5: If no comparator falling edge ends a sample before the next samp_out rise at edge E0', a sample is emitted after edge E0'+3. That sample has raw_data = 2^CNT_W-1 (4095 with the default width) and raw_ovf = 1. The new period's count starts from E0'.
- R6: The averaging exponent is E = avg_exp, capped at 8 for values above 8. After 2^E samples, avg_valid pulses one cycle after the last sample's raw_valid. avg_data then equals floor(sum of the samples / 2^E), and saturated samples are included in the sum.
- R7: avg_exp is sampled when the first sample of a window arrives. A change during a window does not alter that window's length or shift.
- R8: raw_data, raw_ovf and avg_data hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| comp_async | input | 1 | Comparator pulse, asynchronous to clk |
| div_period | input | DIV_W | Sampling period minus one, in clock cycles |
| avg_exp | input | EXP_W | Averaging exponent E; window is 2^E samples |
| samp_out | output | 1 | Sampling signal to the analog reset switch |
| raw_data | output | CNT_W | Latest raw pulse-width sample |
| raw_valid | output | 1 | One-cycle strobe for raw_data |
| raw_ovf | output | 1 | Set when the latest sample had no comparator falling edge |
| avg_data | output | CNT_W | Latest averaged result |
| avg_valid | output | 1 | One-cycle strobe for avg_data |

## Verification
The bench targets the exact strobe cycle for the shortest and longest pulses. A design that left the start uncompensated for synchroniser latency would report counts offset by two. A missing falling edge is checked for a saturated value with the flag set, and that value must also appear in the average; a design that dropped it or wrapped the counter would give the wrong mean. A second fall after a glitch within one period is checked to produce no strobe. An exponent change in mid-window must leave the current window's length unchanged. Exponents above 8 must clamp to 256 samples rather than wrap.

// File: rtl/pulse_avg_pkg.sv
package pulse_avg_pkg;
  typedef enum logic {CNT_IDLE, CNT_RUN} cnt_state_e;
  parameter int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/pa_sample_divider.sv
module pa_sample_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_period,
  output logic             samp_out,
  output logic             samp_start
);
  logic [DIV_W-1:0] per;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             samp_d, start_d;

  always_comb begin
    per     = (div_period == '0) ? DIV_W'(1) : div_period;
    cnt_d   = (cnt_q >= per) ? '0 : cnt_q + 1'b1;
    samp_d  = (cnt_d <= (per >> 1));
    start_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '1;
      samp_out   <= 1'b0;
      samp_start <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      samp_out   <= samp_d;
      samp_start <= start_d;
    end
  end
endmodule

// File: rtl/pa_edge_align.sv
module pa_edge_align #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_in,
  input  logic comp_async,
  output logic start_out,
  output logic comp_fall
);
  logic [STAGES-1:0] comp_sh;
  logic [STAGES-1:0] start_sh;
  logic              comp_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_sh   <= '0;
      start_sh  <= '0;
      comp_prev <= 1'b0;
    end else begin
      comp_sh[0]  <= comp_async;
      start_sh[0] <= start_in;
      for (int i = 1; i < STAGES; i++) begin
        comp_sh[i]  <= comp_sh[i-1];
        start_sh[i] <= start_sh[i-1];
      end
      comp_prev <= comp_sh[STAGES-1];
    end
  end

  assign start_out = start_sh[STAGES-1];
  assign comp_fall = comp_prev & ~comp_sh[STAGES-1];
endmodule

// File: rtl/pa_width_counter.sv
module pa_width_counter
  import pulse_avg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fall,
  output logic [CNT_W-1:0] raw_data,
  output logic             raw_ovf,
  output logic             raw_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  cnt_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, data_d;
  logic             ovf_d, vld_d;

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    st_d    = st_q;
    cnt_d   = cnt_q;
    data_d  = raw_data;
    ovf_d   = raw_ovf;
    vld_d   = 1'b0;
    if (st_q == CNT_RUN) begin
      if (fall) begin
        data_d = cnt_inc;
        ovf_d  = 1'b0;
        vld_d  = 1'b1;
        st_d   = CNT_IDLE;
      end else if (start) begin
        data_d = CNT_MAX;
        ovf_d  = 1'b1;
        vld_d  = 1'b1;
      end else begin
        cnt_d = cnt_inc;
      end
    end
    if (start) begin
      st_d  = CNT_RUN;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= CNT_IDLE;
      cnt_q     <= '0;
      raw_data  <= '0;
      raw_ovf   <= 1'b0;
      raw_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      raw_data  <= data_d;
      raw_ovf   <= ovf_d;
      raw_valid <= vld_d;
    end
  end
endmodule

// File: rtl/pa_averager.sv
module pa_averager #(
  parameter int CNT_W   = 12,
  parameter int EXP_MAX = 8,
  parameter int EXP_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] in_data,
  input  logic [EXP_W-1:0] avg_exp,
  output logic [CNT_W-1:0] avg_data,
  output logic             avg_valid
);
  localparam int ACC_W = CNT_W + EXP_MAX;
  localparam int SC_W  = EXP_MAX + 1;

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic [SC_W-1:0]  n_q, n_d, n_inc, n_target;
  logic [EXP_W-1:0] win_exp_q, win_exp_d, exp_in, exp_use;
  logic [CNT_W-1:0] avg_d;
  logic             vld_d, done;

  always_comb begin
    exp_in    = (avg_exp > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : avg_exp;
    exp_use   = (n_q == '0) ? exp_in : win_exp_q;
    sum       = acc_q + ACC_W'(in_data);
    n_inc     = n_q + 1'b1;
    n_target  = SC_W'(1) << exp_use;
    done      = (n_inc == n_target);
    acc_d     = acc_q;
    n_d       = n_q;
    win_exp_d = win_exp_q;
    avg_d     = avg_data;
    vld_d     = 1'b0;
    if (in_valid) begin
      if (n_q == '0) win_exp_d = exp_in;
      if (done) begin
        avg_d = CNT_W'(sum >> exp_use);
        vld_d = 1'b1;
        acc_d = '0;
        n_d   = '0;
      end else begin
        acc_d = sum;
        n_d   = n_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      n_q       <= '0;
      win_exp_q <= '0;
      avg_data  <= '0;
      avg_valid <= 1'b0;
    end else begin
      avg_valid <= vld_d;
      if (in_valid) begin
        acc_q     <= acc_d;
        n_q       <= n_d;
        win_exp_q <= win_exp_d;
        avg_data  <= avg_d;
      end
    end
  end
endmodule

// File: rtl/pulse_avg_top.sv
module pulse_avg_top
  import pulse_avg_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int DIV_W       = 16,
  parameter int EXP_MAX     = 8,
  parameter int EXP_W       = $clog2(EXP_MAX + 1),
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             comp_async,
  input  logic [DIV_W-1:0] div_period,
  input  logic [EXP_W-1:0] avg_exp,
  output logic             samp_out,
  output logic [CNT_W-1:0] raw_data,
  output logic             raw_valid,
  output logic             raw_ovf,
  output logic [CNT_W-1:0] avg_data,
  output logic             avg_valid
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       samp_start, start_aligned, comp_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pa_sample_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .div_period(div_period),
    .samp_out(samp_out), .samp_start(samp_start)
  );

  pa_edge_align #(.STAGES(SYNC_STAGES)) u_align (
    .clk(clk), .rst_n(rst_int_n), .start_in(samp_start), .comp_async(comp_async),
    .start_out(start_aligned), .comp_fall(comp_fall)
  );

  pa_width_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .start(start_aligned), .fall(comp_fall),
    .raw_data(raw_data), .raw_ovf(raw_ovf), .raw_valid(raw_valid)
  );

  pa_averager #(.CNT_W(CNT_W), .EXP_MAX(EXP_MAX), .EXP_W(EXP_W)) u_avg (
    .clk(clk), .rst_n(rst_int_n), .in_valid(raw_valid), .in_data(raw_data),
    .avg_exp(avg_exp), .avg_data(avg_data), .avg_valid(avg_valid)
  );
endmodule

// File: rtl/pulse_avg_checker.sv
module pulse_avg_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] raw_data,
  input logic             raw_valid,
  input logic             raw_ovf,
  input logic [CNT_W-1:0] avg_data,
  input logic             avg_valid
);
  p_hold_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |-> $stable(raw_data));
  p_hold_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |-> $stable(raw_ovf));
  p_hold_avg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_valid |-> $stable(avg_data));
  p_ovf_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_valid && raw_ovf) |-> (raw_data == {CNT_W{1'b1}}));
  p_avg_after_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> $past(raw_valid));
endmodule

bind pulse_avg_top pulse_avg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .raw_data(raw_data), .raw_valid(raw_valid),
  .raw_ovf(raw_ovf), .avg_data(avg_data), .avg_valid(avg_valid)
);

// File: tb/pulse_avg_top_tb_top.sv
`timescale 1ns/1ps
module pulse_avg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, comp_async;
  logic [15:0] div_period;
  logic [3:0]  avg_exp;
  logic        samp_out, raw_valid, raw_ovf, avg_valid;
  logic [11:0] raw_data, avg_data;

  always #2.5 clk = ~clk;

  pulse_avg_top dut_i (
    .clk(clk), .rst_n(rst_n), .comp_async(comp_async), .div_period(div_period),
    .avg_exp(avg_exp), .samp_out(samp_out), .raw_data(raw_data), .raw_valid(raw_valid),
    .raw_ovf(raw_ovf), .avg_data(avg_data), .avg_valid(avg_valid)
  );

  int checks = 0, fails = 0;
  int exp_win = 0, acc_m = 0, n_m = 0, last_avg = 0, cur_exp = 0, since = 0;
  bit at_rise = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int clamp_e(int e);
    return (e > 8) ? 8 : e;
  endfunction

  task automatic wait_rise();
    bit prev;
    prev = samp_out;
    forever begin
      @(negedge clk);
      if (samp_out && !prev) break;
      prev = samp_out;
    end
  endtask

  task automatic check_reset_state();
    chk(samp_out == 0 && raw_valid == 0 && avg_valid == 0 && raw_ovf == 0,
        "R1 reset strobes", {samp_out, raw_valid, avg_valid, raw_ovf}, 0);
    chk(raw_data == 0 && avg_data == 0, "R1 reset data", raw_data + avg_data, 0);
  endtask

  task automatic measure(int per_exp, int high_exp);
    int  p, h;
    bit  prev;
    wait_rise();
    p = 0; h = 1; prev = 1'b1;
    forever begin
      @(negedge clk);
      p++;
      if (samp_out && !prev) break;
      if (samp_out) h++;
      prev = samp_out;
    end
    chk(p == per_exp, "R2 period", p, per_exp);
    chk(h == high_exp, "R2 high time", h, high_exp);
  endtask

  task automatic expect_avg(int v, string atag);
    int e;
    if (n_m == 0) exp_win = clamp_e(cur_exp);
    acc_m += v;
    n_m++;
    @(negedge clk);
    chk(raw_valid == 0 && raw_data == v, "R8 raw held", raw_data, v);
    if (n_m == (1 << exp_win)) begin
      e = acc_m >> exp_win;
      chk(avg_valid == 1 && avg_data == e, atag, avg_data, e);
      last_avg = e; acc_m = 0; n_m = 0;
    end else begin
      chk(avg_valid == 0 && avg_data == last_avg, "R8 avg held", avg_data, last_avg);
    end
  endtask

  task automatic run_sample(int len, bit glitch, string atag);
    if (!at_rise) begin wait_rise(); since = 0; end
    comp_async = 1'b1;
    repeat (len - since) @(negedge clk);
    comp_async = 1'b0;
    at_rise = 0;
    repeat (2) @(negedge clk);
    chk(raw_valid == 0, "R3 no early strobe", raw_valid, 0);
    @(negedge clk);
    chk(raw_valid == 1 && raw_data == len && raw_ovf == 0, "R3 count", raw_data, len);
    expect_avg(len, atag);
    if (glitch) begin
      comp_async = 1'b1;
      repeat (2) @(negedge clk);
      comp_async = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(raw_valid == 0, "R4 second fall ignored", raw_valid, 0);
      end
    end
  endtask

  task automatic run_miss(string atag);
    if (!at_rise) wait_rise();
    comp_async = 1'b1;
    wait_rise();
    repeat (2) @(negedge clk);
    chk(raw_valid == 0, "R5 no early strobe", raw_valid, 0);
    @(negedge clk);
    chk(raw_valid == 1 && raw_data == 4095 && raw_ovf == 1, "R5 overflow sample", raw_data, 4095);
    expect_avg(4095, atag);
    since = 4;
    at_rise = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; comp_async = 1'b0; div_period = 16'd63; avg_exp = 4'd0;
    repeat (4) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;

    measure(64, 32);
    div_period = 16'd9;  wait_rise(); measure(10, 5);
    div_period = 16'd0;  wait_rise(); measure(2, 1);

    rst_n = 1'b0;
    div_period = 16'd63;
    repeat (3) @(negedge clk);
    check_reset_state();
    cur_exp = 0; acc_m = 0; n_m = 0; last_avg = 0; at_rise = 0;
    rst_n = 1'b1;

    // R3 boundaries and random lengths, one-sample windows
    run_sample(1, 0, "R6 exp0");
    run_sample(58, 0, "R6 exp0");
    for (int i = 0; i < 4; i++) run_sample($urandom_range(58, 1), 0, "R6 exp0");

    // R5: saturated value enters a four-sample average
    avg_exp = 4'd2; cur_exp = 2;
    run_sample($urandom_range(50, 1), 0, "R6 exp2");
    run_sample($urandom_range(50, 1), 0, "R6 exp2");
    run_miss("R5 saturated value averaged");
    run_sample($urandom_range(50, 5), 0, "R5 saturated value averaged");

    // R4: glitch after the first fall
    run_sample(10, 1, "R6 exp2");
    for (int i = 0; i < 3; i++) run_sample($urandom_range(58, 1), 0, "R6 exp2");

    // R7: exponent change inside an open window
    avg_exp = 4'd3; cur_exp = 3;
    run_sample($urandom_range(58, 1), 0, "R7 deferred exponent");
    run_sample($urandom_range(58, 1), 0, "R7 deferred exponent");
    avg_exp = 4'd1; cur_exp = 1;
    for (int i = 0; i < 6; i++) run_sample($urandom_range(58, 1), 0, "R7 deferred exponent");
    run_sample($urandom_range(58, 1), 0, "R7 new exponent");
    run_sample($urandom_range(58, 1), 0, "R7 new exponent");

    // R6: exponent above 8 clamps to a 256-sample window
    avg_exp = 4'd12; cur_exp = 12;
    for (int i = 0; i < 256; i++) run_sample($urandom_range(58, 1), 0, "R6 clamped window");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule